// File: doc/BRIEF.md
# DSP-Mode PCM Serial Shifter

This block is the serial data engine of a PCM audio port that always acts as bit-clock and frame master. A separate clock generator tells it where the bit-clock edges are. It gives a one-cycle `drive_tick` at each rising bit-clock edge and a one-cycle `sample_tick` at each falling edge. On the drive tick that opens the frame-sync bit, the generator also raises `sync_mark`. The shifter pops 16-bit words from a transmit FIFO and sends them MSB first on `sdo`. It shifts `sdi` into 16-bit words and pushes them into a receive FIFO. Each frame carries two channel words, one directly after the other.

Each direction has its own alignment bit. When the bit is 1, the first MSB sits one bit clock after the frame-sync bit. When the bit is 0, the MSB shares the bit clock with the frame sync. The shifter captures the alignment bit at each frame sync.

Start and stop commands switch each direction on and off. A start also raises the shared port enable. A stop lowers the port enable only when the other direction is already off. A direction that has been started waits for the next frame sync before it moves any data.

Timing assumptions: the bit period is at least four system clocks, and `sample_tick` comes at least two clocks after the matching `drive_tick`. `sdo` takes its new value two clocks after `drive_tick`.

Top module: `pcm_dsp_shifter`

## Requirements
- R1: After synchronous reset, `sdo`, `tx_pop`, `tx_starve`, `rx_push`, `rx_overrun`, `port_en`, `tx_run` and `rx_run` are all 0.
- R2: A one-cycle `tx_start` (or `rx_start`) pulse sets `tx_run` (or `rx_run`) and `port_en` to 1 on the next clock.
- R3: A stop pulse clears that direction's run flag. It clears `port_en` only if the other direction's run flag is 0 after the same clock.
- R4: A direction that is stopped, or started but has not yet seen a `sync_mark` drive tick, holds `sdo` at 0 and produces no `tx_pop`, `rx_push`, `tx_starve` or `rx_overrun`.
- R5: Number the bit clocks of a frame from 0, where bit 0 is the `sync_mark` bit. With `tx_late`=0, bits 0..15 carry channel-0 MSB first and bits 16..31 carry channel-1. With `tx_late`=1 the same words sit in bits 1..32.
- R6: The receiver samples `sdi` on sample ticks. It uses the same numbering with `rx_late`. At the last bit of each word it pulses `rx_push` with `rx_word` holding that word, channel-0 first. `sdi` values outside the word slots have no effect.
- R7: Each alignment bit is captured at the frame's sync. Changing `tx_late` or `rx_late` during a frame does not change that frame's layout. The two directions may use different settings in the same frame.
- R8: In every bit clock of a running transmit frame that is not part of a word slot, `sdo` is 0. This covers the bit before the MSB when `tx_late`=1 and all bits after the second word.
- R9: If `tx_avail` is 0 when a transmit word starts, the word is sent as all zeros. `tx_starve` pulses once and no `tx_pop` is issued. Otherwise exactly one `tx_pop` pulses for that word.
- R10: If `rx_room` is 0 when a received word completes, the word is dropped: `rx_overrun` pulses once and `rx_push` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Start-transmit command pulse |
| tx_stop | input | 1 | Stop-transmit command pulse |
| rx_start | input | 1 | Start-receive command pulse |
| rx_stop | input | 1 | Stop-receive command pulse |
| tx_late | input | 1 | Transmit alignment: 1 = MSB one bit after sync, 0 = MSB on sync bit |
| rx_late | input | 1 | Receive alignment, same encoding as `tx_late` |
| drive_tick | input | 1 | One-cycle strobe at each rising bit-clock edge |
| sample_tick | input | 1 | One-cycle strobe at each falling bit-clock edge |
| sync_mark | input | 1 | With `drive_tick`, marks the frame-sync bit |
| tx_word | input | 16 | Head word of the transmit FIFO |
| tx_avail | input | 1 | Transmit FIFO is not empty |
| tx_pop | output | 1 | Pops the head of the transmit FIFO |
| tx_starve | output | 1 | Pulse: a transmit word started while the FIFO was empty |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |
| rx_room | input | 1 | Receive FIFO has space |
| rx_word | output | 16 | Received word, valid with `rx_push` |
| rx_push | output | 1 | Writes `rx_word` into the receive FIFO |
| rx_overrun | output | 1 | Pulse: a received word was dropped |
| port_en | output | 1 | Shared port enable |
| tx_run | output | 1 | Transmit direction is on |
| rx_run | output | 1 | Receive direction is on |

## Verification
A slot tracker that has lost its frame position shows up within one frame. It moves every serial bit on `sdo` out of place, sends words early or late, or leaves extra or missing zero bits, and it changes the cycle in which `rx_push` arrives. A wrong captured alignment bit shifts the whole word by one bit clock, so the first MSB in that frame is already wrong. A wrong enable or run flag shows at the status ports on the clock after the command. A shift register that keeps stale bits corrupts the next word's value the first time that word is pushed or sent.

// File: rtl/pcm_shift_pkg.sv
package pcm_shift_pkg;

  // Per-direction position of the current bit clock within the frame
  typedef struct packed {
    logic in_data;     // bit belongs to one of the channel word slots
    logic word_start;  // first (MSB) bit of a word slot
    logic word_last;   // last (LSB) bit of a word slot
  } slot_t;

endpackage

// File: rtl/pcm_run_ctrl.sv
module pcm_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tx_start,
  input  logic tx_stop,
  input  logic rx_start,
  input  logic rx_stop,
  output logic port_en,
  output logic tx_run,
  output logic rx_run
);

  logic tx_nx, rx_nx, en_nx;

  always_comb begin
    tx_nx = tx_start ? 1'b1 : (tx_stop ? 1'b0 : tx_run);
    rx_nx = rx_start ? 1'b1 : (rx_stop ? 1'b0 : rx_run);
    en_nx = port_en;
    if (tx_start || rx_start)
      en_nx = 1'b1;
    else if ((tx_stop || rx_stop) && !tx_nx && !rx_nx)
      en_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_en <= 1'b0;
      tx_run  <= 1'b0;
      rx_run  <= 1'b0;
    end else begin
      port_en <= en_nx;
      tx_run  <= tx_nx;
      rx_run  <= rx_nx;
    end
  end

  // R3
  en_covers_run_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_run || rx_run) |-> port_en);

  // R3
  en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(port_en) |-> (!tx_run && !rx_run));

  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> (tx_run && port_en));

endmodule

// File: rtl/pcm_slot_track.sv
module pcm_slot_track
  import pcm_shift_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CHANS    = 2,
  parameter int POS_W    = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  drive_tick,
  input  logic  sync_mark,
  input  logic  late,
  output slot_t slot
);

  localparam int DATA_BITS = SAMPLE_W * CHANS;
  localparam int BIT_W     = $clog2(SAMPLE_W);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] idx;
  logic             late_q;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      late_q <= 1'b0;
      armed  <= 1'b0;
    end else if (!run) begin
      pos    <= '0;
      armed  <= 1'b0;
    end else if (drive_tick) begin
      if (sync_mark) begin
        pos    <= '0;
        late_q <= late;
        armed  <= 1'b1;
      end else if (armed && (pos != {POS_W{1'b1}})) begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign idx = pos - POS_W'(late_q);

  always_comb begin
    slot.in_data    = armed && (pos >= POS_W'(late_q)) && (idx < POS_W'(DATA_BITS));
    slot.word_start = slot.in_data && (idx[BIT_W-1:0] == '0);
    slot.word_last  = slot.in_data && (idx[BIT_W-1:0] == {BIT_W{1'b1}});
  end

  // R4
  arm_at_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(run && drive_tick && sync_mark));

  // R5
  start_last_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(slot.word_start && slot.word_last));

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_shift_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                drive_tick,
  input  slot_t               slot,
  input  logic [SAMPLE_W-1:0] tx_word,
  input  logic                tx_avail,
  output logic                tx_pop,
  output logic                tx_starve,
  output logic                sdo
);

  logic [SAMPLE_W-1:0] shreg;
  logic                tick_q;

  // Wait one clock after the drive tick so the slot tracker has moved
  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= drive_tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo       <= 1'b0;
      shreg     <= '0;
      tx_pop    <= 1'b0;
      tx_starve <= 1'b0;
    end else begin
      tx_pop    <= 1'b0;
      tx_starve <= 1'b0;
      if (!run) begin
        sdo   <= 1'b0;
        shreg <= '0;
      end else if (tick_q) begin
        if (!slot.in_data) begin
          sdo <= 1'b0;
        end else if (slot.word_start) begin
          if (tx_avail) begin
            sdo    <= tx_word[SAMPLE_W-1];
            shreg  <= {tx_word[SAMPLE_W-2:0], 1'b0};
            tx_pop <= 1'b1;
          end else begin
            sdo       <= 1'b0;
            shreg     <= '0;
            tx_starve <= 1'b1;
          end
        end else begin
          sdo   <= shreg[SAMPLE_W-1];
          shreg <= slot.word_last ? '0 : {shreg[SAMPLE_W-2:0], 1'b0};
        end
      end
    end
  end

  // R9
  pop_starve_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_pop && tx_starve));

  // R9
  starve_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_starve |-> $past(!tx_avail));

  // R4
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sdo && !tx_pop && !tx_starve));

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_shift_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                sample_tick,
  input  slot_t               slot,
  input  logic                sdi,
  input  logic                rx_room,
  output logic [SAMPLE_W-1:0] rx_word,
  output logic                rx_push,
  output logic                rx_overrun
);

  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] shifted;

  // A word start clears whatever the previous word left behind
  assign shifted = slot.word_start ? {{(SAMPLE_W-1){1'b0}}, sdi}
                                   : {shreg[SAMPLE_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      rx_word    <= '0;
      rx_push    <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      rx_push    <= 1'b0;
      rx_overrun <= 1'b0;
      if (!run) begin
        shreg <= '0;
      end else if (sample_tick && slot.in_data) begin
        shreg <= shifted;
        if (slot.word_last) begin
          if (rx_room) begin
            rx_word <= shifted;
            rx_push <= 1'b1;
          end else begin
            rx_overrun <= 1'b1;
          end
        end
      end
    end
  end

  // R10
  push_ovr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_push && rx_overrun));

  // R10
  push_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $past(rx_room));

  // R4
  rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!rx_push && !rx_overrun));

endmodule

// File: rtl/pcm_dsp_shifter.sv
module pcm_dsp_shifter
  import pcm_shift_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CHANS    = 2,
  parameter int POS_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_start,
  input  logic                tx_stop,
  input  logic                rx_start,
  input  logic                rx_stop,
  input  logic                tx_late,
  input  logic                rx_late,
  input  logic                drive_tick,
  input  logic                sample_tick,
  input  logic                sync_mark,
  input  logic [SAMPLE_W-1:0] tx_word,
  input  logic                tx_avail,
  output logic                tx_pop,
  output logic                tx_starve,
  output logic                sdo,
  input  logic                sdi,
  input  logic                rx_room,
  output logic [SAMPLE_W-1:0] rx_word,
  output logic                rx_push,
  output logic                rx_overrun,
  output logic                port_en,
  output logic                tx_run,
  output logic                rx_run
);

  slot_t tx_slot, rx_slot;
  logic  tx_go, rx_go;

  assign tx_go = port_en && tx_run;
  assign rx_go = port_en && rx_run;

  pcm_run_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .tx_start(tx_start), .tx_stop(tx_stop),
    .rx_start(rx_start), .rx_stop(rx_stop),
    .port_en(port_en), .tx_run(tx_run), .rx_run(rx_run)
  );

  pcm_slot_track #(.SAMPLE_W(SAMPLE_W), .CHANS(CHANS), .POS_W(POS_W)) u_tx_track (
    .clk(clk), .rst(rst), .run(tx_go), .drive_tick(drive_tick),
    .sync_mark(sync_mark), .late(tx_late), .slot(tx_slot)
  );

  pcm_slot_track #(.SAMPLE_W(SAMPLE_W), .CHANS(CHANS), .POS_W(POS_W)) u_rx_track (
    .clk(clk), .rst(rst), .run(rx_go), .drive_tick(drive_tick),
    .sync_mark(sync_mark), .late(rx_late), .slot(rx_slot)
  );

  pcm_tx_lane #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk(clk), .rst(rst), .run(tx_go), .drive_tick(drive_tick),
    .slot(tx_slot), .tx_word(tx_word), .tx_avail(tx_avail),
    .tx_pop(tx_pop), .tx_starve(tx_starve), .sdo(sdo)
  );

  pcm_rx_lane #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst(rst), .run(rx_go), .sample_tick(sample_tick),
    .slot(rx_slot), .sdi(sdi), .rx_room(rx_room),
    .rx_word(rx_word), .rx_push(rx_push), .rx_overrun(rx_overrun)
  );

endmodule

// File: tb/test_pcm_dsp_shifter.sv
module test_pcm_dsp_shifter;

  localparam int FB  = 40;   // bit clocks per frame
  localparam int BP  = 8;    // system clocks per bit clock
  localparam int SPH = 4;    // phase of the sample tick

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_start = 0, tx_stop = 0, rx_start = 0, rx_stop = 0;
  logic tx_late = 0, rx_late = 0;
  logic drive_tick = 0, sample_tick = 0, sync_mark = 0;
  logic [15:0] tx_word = '0;
  logic tx_avail = 0;
  logic sdi = 0, rx_room = 1;
  logic tx_pop, tx_starve, sdo, rx_push, rx_overrun, port_en, tx_run, rx_run;
  logic [15:0] rx_word;

  always #5 clk = ~clk;

  pcm_dsp_shifter i_pcm_dsp_shifter (
    .clk(clk), .rst(rst),
    .tx_start(tx_start), .tx_stop(tx_stop), .rx_start(rx_start), .rx_stop(rx_stop),
    .tx_late(tx_late), .rx_late(rx_late),
    .drive_tick(drive_tick), .sample_tick(sample_tick), .sync_mark(sync_mark),
    .tx_word(tx_word), .tx_avail(tx_avail), .tx_pop(tx_pop), .tx_starve(tx_starve),
    .sdo(sdo), .sdi(sdi), .rx_room(rx_room), .rx_word(rx_word), .rx_push(rx_push),
    .rx_overrun(rx_overrun), .port_en(port_en), .tx_run(tx_run), .rx_run(rx_run)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] txq[$];
  logic [15:0] rx_exp[$];
  int pops, starves, pushes, ovrs;
  logic tx_on = 0, rx_on = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic tx_bit(int pos, logic late, logic [15:0] w0, logic [15:0] w1);
    int d;
    if (pos < int'(late)) return 1'b0;
    d = pos - int'(late);
    if (d < 16) return w0[15-d];
    if (d < 32) return w1[31-d];
    return 1'b0;
  endfunction

  function automatic logic rx_bit(int pos, logic late, logic [15:0] r0, logic [15:0] r1);
    int d;
    d = pos - int'(late);
    if (pos < int'(late) || d >= 32) return 1'($urandom);
    if (d < 16) return r0[15-d];
    return r1[31-d];
  endfunction

  task automatic refresh_tx;
    tx_avail = (txq.size() != 0);
    tx_word  = tx_avail ? txq[0] : 16'h0;
  endtask

  task automatic monitor;
    if (tx_pop) begin
      if (txq.size() != 0) void'(txq.pop_front());
      pops++;
    end
    if (tx_starve) starves++;
    if (rx_push) begin
      if (rx_exp.size() != 0) begin
        chk("R6 rx_word", {16'h0, rx_word}, {16'h0, rx_exp[0]});
        void'(rx_exp.pop_front());
      end
      pushes++;
    end
    if (rx_overrun) ovrs++;
    refresh_tx();
  endtask

  // One frame; with_sync=0 gives bit clocks with no frame sync
  task automatic run_frame(input bit with_sync, input logic [15:0] r0, input logic [15:0] r1,
                           input bit flip);
    logic [15:0] w0, w1;
    logic tl, rl;
    int n, exp_pops, exp_starve, exp_push, exp_ovr;
    n  = txq.size();
    w0 = (n > 0) ? txq[0] : 16'h0;
    w1 = (n > 1) ? txq[1] : 16'h0;
    tl = tx_late; rl = rx_late;
    exp_pops   = (tx_on && with_sync) ? ((n > 2) ? 2 : n) : 0;
    exp_starve = (tx_on && with_sync) ? 2 - exp_pops : 0;
    exp_push   = (rx_on && with_sync && rx_room) ? 2 : 0;
    exp_ovr    = (rx_on && with_sync && !rx_room) ? 2 : 0;
    rx_exp.delete();
    if (exp_push != 0) begin rx_exp.push_back(r0); rx_exp.push_back(r1); end
    pops = 0; starves = 0; pushes = 0; ovrs = 0;
    for (int b = 0; b < FB; b++) begin
      for (int ph = 0; ph < BP; ph++) begin
        @(negedge clk);
        monitor();
        drive_tick  = (ph == 0);
        sync_mark   = (ph == 0) && (b == 0) && with_sync;
        sample_tick = (ph == SPH);
        if (ph == 0) sdi = rx_bit(b, rl, r0, r1);
        if (ph == 0 && b == 10 && flip) begin tx_late = ~tx_late; rx_late = ~rx_late; end
        if (ph == 3) begin
          // R5 R7 R8: serial bit vs layout captured at sync
          if (tx_on && with_sync) chk("R5/R8 sdo", {31'h0, sdo}, {31'h0, tx_bit(b, tl, w0, w1)});
          else                    chk("R4 sdo idle", {31'h0, sdo}, 32'h0);
        end
      end
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      monitor();
      drive_tick = 0; sync_mark = 0; sample_tick = 0;
    end
    tx_late = tl; rx_late = rl;
    chk("R9 pops", pops, exp_pops);
    chk("R9 starve", starves, exp_starve);
    chk("R6 pushes", pushes, exp_push);
    chk("R10 overrun", ovrs, exp_ovr);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    monitor();
    case (which)
      0: tx_start = 1; 1: tx_stop = 1; 2: rx_start = 1; default: rx_stop = 1;
    endcase
    @(negedge clk);
    monitor();
    tx_start = 0; tx_stop = 0; rx_start = 0; rx_stop = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 outputs", {24'h0, sdo, tx_pop, tx_starve, rx_push, rx_overrun, port_en, tx_run, rx_run}, 32'h0);

    // R2: start transmit
    pulse(0);
    chk("R2 tx start", {29'h0, port_en, tx_run, rx_run}, 32'h6);
    tx_on = 1;
    // R4: started but no sync yet
    txq.push_back(16'hA5C3); txq.push_back(16'h0F0F); refresh_tx();
    tx_on = 0;
    run_frame(0, 16'h0, 16'h0, 0);
    tx_on = 1;
    chk("R4 queue untouched", txq.size(), 2);
    pulse(2);
    chk("R2 rx start", {29'h0, port_en, tx_run, rx_run}, 32'h7);
    rx_on = 1;

    // Directed: both alignments, both directions (R5 R6)
    tx_late = 0; rx_late = 0;
    run_frame(1, 16'h8001, 16'h7FFE, 0);
    txq.push_back(16'hFFFF); txq.push_back(16'h0001); refresh_tx();
    tx_late = 1; rx_late = 1;
    run_frame(1, 16'hC0DE, 16'h1234, 0);
    // R7: mixed modes, then a mid-frame flip of both bits
    txq.push_back(16'h5A5A); txq.push_back(16'h3C3C); refresh_tx();
    tx_late = 1; rx_late = 0;
    run_frame(1, 16'hBEEF, 16'h4321, 1);

    // Random frames
    for (int f = 0; f < 14; f++) begin
      txq.push_back(16'($urandom)); txq.push_back(16'($urandom)); refresh_tx();
      tx_late = 1'($urandom); rx_late = 1'($urandom);
      run_frame(1, 16'($urandom), 16'($urandom), f[0]);
    end

    // R9: empty FIFO, then one word only
    txq.delete(); refresh_tx();
    run_frame(1, 16'h1111, 16'h2222, 0);
    txq.push_back(16'hF00D); refresh_tx();
    tx_late = 0;
    run_frame(1, 16'h3333, 16'h4444, 0);

    // R10: receive FIFO full
    txq.push_back(16'h1357); txq.push_back(16'h2468); refresh_tx();
    rx_room = 0;
    run_frame(1, 16'hAAAA, 16'h5555, 0);
    rx_room = 1;
    // R6: a push after the drops still carries clean words
    txq.push_back(16'h0102); txq.push_back(16'h0304); refresh_tx();
    run_frame(1, 16'h0F0F, 16'hF0F0, 0);

    // R3: stop transmit while receive stays on
    pulse(1);
    tx_on = 0;
    chk("R3 tx stop keeps enable", {29'h0, port_en, tx_run, rx_run}, 32'h5);
    txq.delete(); txq.push_back(16'hDEAD); txq.push_back(16'hBEEF); refresh_tx();
    run_frame(1, 16'h6789, 16'h9876, 0);
    chk("R4 stopped tx no pop", txq.size(), 2);
    // R3: stop receive, enable drops
    pulse(3);
    rx_on = 0;
    chk("R3 rx stop clears enable", {29'h0, port_en, tx_run, rx_run}, 32'h0);
    run_frame(1, 16'h1357, 16'h2468, 0);

    finish_run();
  end

endmodule